// File: doc/BRIEF.md
# Data-Processing Shifter Operand Unit

This purely combinational unit forms the second source operand of a data-processing instruction and the carry bit that operand produces. It looks at the low twelve instruction bits and the immediate-select bit. It then builds one of three operand forms:

- an 8-bit constant rotated inside a 32-bit word;
- the Rm register value shifted by a 5-bit amount held in the instruction;
- the Rm value shifted by the low byte of the Rs register.

The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the incoming carry flag. Register-file reads and the ALU sit outside the unit.

The carry output follows exact rules at shift amounts of 0, 32 and above 32. An immediate shift field of zero has a special meaning for the right-shift kinds. The unit also recognises the encodings that belong to the arithmetic and load/store extension space rather than to the operand decoder. It flags those and forces a fixed output.

Top module: `opnd_shifter`

## Requirements
- R1: With `imm_sel`=1, `operand` is `instr_lo[7:0]` zero-extended to 32 bits and rotated right by twice `instr_lo[11:8]`.
- R2: With `imm_sel`=1, `carry_out` equals `c_flag` when `instr_lo[11:8]` is 0, and equals bit 31 of `operand` otherwise.
- R3: With `imm_sel`=0, `instr_lo[4]`=0 and kind `instr_lo[6:5]`=00 (left shift), Rm is shifted left by n=`instr_lo[11:7]` (0..31) with zero fill. The carry is Rm[32-n], or `c_flag` when n=0.
- R4: With `imm_sel`=0 and `instr_lo[4]`=0, kinds 01 (logical right) and 10 (arithmetic right) shift by `instr_lo[11:7]`, and a field of 0 means 32. The carry is Rm[n-1], so a shift of 32 gives Rm[31]. The logical form fills with zeros and the arithmetic form fills with Rm[31].
- R5: With `imm_sel`=0, `instr_lo[4]`=0 and kind 11, a nonzero field n rotates Rm right by n with carry Rm[n-1]. A zero field rotates right by one with `c_flag` entering bit 31 and carry Rm[0].
- R6: With `imm_sel`=0, `instr_lo[7]`=0 and `instr_lo[4]`=1, the amount is `rs_lo`. An amount of 0 passes Rm unchanged with carry `c_flag`, for every kind.
- R7: Register left shift: an amount n in 1..31 gives carry Rm[32-n]. An amount of 32 gives operand 0 and carry Rm[0]. An amount above 32 gives operand 0 and carry 0.
- R8: Register logical right shift: an amount n in 1..31 gives carry Rm[n-1]. An amount of 32 gives operand 0 and carry Rm[31]. An amount above 32 gives operand 0 and carry 0.
- R9: Register arithmetic right shift: an amount n in 1..31 gives carry Rm[n-1]. An amount of 32 or more gives 32 copies of Rm[31] and carry Rm[31].
- R10: Register rotate with nonzero `rs_lo` rotates right by `rs_lo[4:0]` with carry equal to bit 31 of the result. When `rs_lo[4:0]` is 0, the result is Rm and the carry is Rm[31].
- R11: When `imm_sel`=0, `instr_lo[7]`=1 and `instr_lo[4]`=1, `ext_space` is 1, `operand` is 0 and `carry_out` equals `c_flag`. `ext_space` is 0 for every other encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_lo | input | 12 | Instruction bits 11:0 |
| imm_sel | input | 1 | Immediate-form select (instruction bit 25) |
| rm_val | input | 32 | Value of the Rm register |
| rs_lo | input | 8 | Low byte of the Rs register |
| c_flag | input | 1 | Current carry flag |
| operand | output | 32 | Shifter operand |
| carry_out | output | 1 | Shifter carry-out |
| ext_space | output | 1 | Encoding is in the extension space |

## Verification
The in-line assertions check several invariants each time the inputs settle:

- an immediate rotation keeps the number of set bits;
- a zero amount passes Rm and the carry flag through;
- over-range logical shifts clear both outputs;
- over-range arithmetic shifts replicate the sign;
- the extension-space output is forced.

Exact operand values and the carry bit chosen at each boundary (amounts 0, 1, 31, 32, 33 and 255, rotate fields that alias to zero, and the one-bit rotate through the carry) can only be shown by the bench's vectors and sweeps.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    OF_ROT_IMM   = 2'b00,
    OF_SHIFT_IMM = 2'b01,
    OF_SHIFT_REG = 2'b10,
    OF_EXT       = 2'b11
  } opnd_form_e;

endpackage

// File: rtl/opnd_field_dec.sv
module opnd_field_dec
  import opnd_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [11:0]      instr_lo,
  input  logic             imm_sel,
  input  logic [AMT_W-1:0] rs_lo,
  output opnd_form_e       form,
  output shift_kind_e      kind,
  output logic [AMT_W-1:0] amt,
  output logic             rrx
);
  localparam int IMM_SH_W = 5;
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [IMM_SH_W-1:0] imm_sh;

  always_comb begin
    imm_sh = instr_lo[11:7];
    kind   = shift_kind_e'(instr_lo[6:5]);
    amt    = '0;
    rrx    = 1'b0;
    if (imm_sel) begin
      form = OF_ROT_IMM;
    end else if (instr_lo[4] && instr_lo[7]) begin
      form = OF_EXT;
    end else if (instr_lo[4]) begin
      form = OF_SHIFT_REG;
      amt  = rs_lo;
    end else begin
      form = OF_SHIFT_IMM;
      amt  = AMT_W'(imm_sh);
      if (imm_sh == '0) begin
        unique case (kind)
          SK_LSR, SK_ASR: amt = FULL_AMT;
          SK_ROR:         rrx = 1'b1;
          default:        amt = '0;
        endcase
      end
    end
  end

  // R11: the extension form is never taken for an immediate operand
  always_comb begin
    if (!$isunknown({imm_sel, instr_lo})) begin
      p_ext_not_imm_r11: assert (!(form == OF_EXT && imm_sel))
        else $error("extension form decoded with immediate select");
    end
  end

endmodule

// File: rtl/opnd_imm_rot.sv
module opnd_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             c_in,
  output logic [DATA_W-1:0] val,
  output logic             cy
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]   imm_ext;
  logic [2*DATA_W-1:0] dbl;
  logic [SH_W-1:0]     rot_amt;

  always_comb begin
    imm_ext = DATA_W'(imm);
    rot_amt = SH_W'({rot, 1'b0});
    dbl     = {imm_ext, imm_ext} >> rot_amt;
    val     = dbl[DATA_W-1:0];
    cy      = (rot == '0) ? c_in : val[DATA_W-1];
  end

  // R1: rotation keeps the count of set bits
  always_comb begin
    if (!$isunknown({imm, rot})) begin
      p_rot_ones_r1: assert ($countones(val) == $countones(imm))
        else $error("rotated immediate changed its set-bit count");
    end
  end

endmodule

// File: rtl/opnd_barrel.sv
module opnd_barrel
  import opnd_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] rm,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rrx,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              cy
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W:0]        lsl_ext;
  logic [DATA_W:0]        lsr_ext;
  logic signed [DATA_W:0] asr_ext;
  logic [2*DATA_W-1:0]    ror_dbl;
  logic [SH_W-1:0]        ror_amt;

  // Extra bit below/above the word catches the last bit shifted out.
  always_comb begin
    lsl_ext = {1'b0, rm} << amt;
    lsr_ext = {rm, 1'b0} >> amt;
    asr_ext = $signed({rm, 1'b0}) >>> amt;
    ror_amt = amt[SH_W-1:0];
    ror_dbl = {rm, rm} >> ror_amt;
  end

  always_comb begin
    res = rm;
    cy  = c_in;
    if (rrx) begin
      res = {c_in, rm[DATA_W-1:1]};
      cy  = rm[0];
    end else if (amt != '0) begin
      unique case (kind)
        SK_LSL: begin
          res = lsl_ext[DATA_W-1:0];
          cy  = lsl_ext[DATA_W];
        end
        SK_LSR: begin
          res = lsr_ext[DATA_W:1];
          cy  = lsr_ext[0];
        end
        SK_ASR: begin
          res = asr_ext[DATA_W:1];
          cy  = asr_ext[0];
        end
        default: begin
          res = ror_dbl[DATA_W-1:0];
          cy  = ror_dbl[DATA_W-1];
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({rm, kind, amt, rrx, c_in})) begin
      // R6: zero amount passes the value and the carry flag through
      p_zero_pass_r6: assert (rrx || amt != '0 || (res == rm && cy == c_in))
        else $error("zero shift altered operand");
      // R8: logical right beyond the word clears value and carry
      p_lsr_over_r8: assert (!(kind == SK_LSR && !rrx && amt > AMT_W'(DATA_W))
                             || (res == '0 && !cy))
        else $error("over-range logical right not cleared");
      // R9: arithmetic right at or beyond the word replicates the sign
      p_asr_sign_r9: assert (!(kind == SK_ASR && !rrx && amt >= AMT_W'(DATA_W))
                             || ($countones(res) == (rm[DATA_W-1] ? DATA_W : 0)
                                 && cy == rm[DATA_W-1]))
        else $error("over-range arithmetic right lost the sign");
      // R10: a rotation keeps the count of set bits
      p_ror_ones_r10: assert (!(kind == SK_ROR && !rrx)
                              || $countones(res) == $countones(rm))
        else $error("rotation changed the set-bit count");
    end
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [11:0]       instr_lo,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [AMT_W-1:0]  rs_lo,
  input  logic              c_flag,
  output logic [DATA_W-1:0] operand,
  output logic              carry_out,
  output logic              ext_space
);
  localparam int IMM_W = 8;
  localparam int ROT_W = 4;

  opnd_form_e        form;
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt;
  logic              rrx;
  logic [DATA_W-1:0] rot_val;
  logic              rot_cy;
  logic [DATA_W-1:0] sh_val;
  logic              sh_cy;

  opnd_field_dec #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .instr_lo (instr_lo),
    .imm_sel  (imm_sel),
    .rs_lo    (rs_lo),
    .form     (form),
    .kind     (kind),
    .amt      (amt),
    .rrx      (rrx)
  );

  opnd_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm  (instr_lo[IMM_W-1:0]),
    .rot  (instr_lo[11:8]),
    .c_in (c_flag),
    .val  (rot_val),
    .cy   (rot_cy)
  );

  opnd_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .rm   (rm_val),
    .kind (kind),
    .amt  (amt),
    .rrx  (rrx),
    .c_in (c_flag),
    .res  (sh_val),
    .cy   (sh_cy)
  );

  always_comb begin
    ext_space = (form == OF_EXT);
    unique case (form)
      OF_ROT_IMM: begin
        operand   = rot_val;
        carry_out = rot_cy;
      end
      OF_EXT: begin
        operand   = '0;
        carry_out = c_flag;
      end
      default: begin
        operand   = sh_val;
        carry_out = sh_cy;
      end
    endcase
  end

  // R11: extension encodings force a zero operand and keep the carry flag
  always_comb begin
    if (!$isunknown({instr_lo, imm_sel, c_flag})) begin
      p_ext_out_r11: assert (!ext_space || (operand == '0 && carry_out == c_flag))
        else $error("extension encoding leaked an operand");
    end
  end

endmodule

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;

  logic        clk;
  logic        rst_n;
  logic [11:0] instr_lo;
  logic        imm_sel;
  logic [31:0] rm_val;
  logic [7:0]  rs_lo;
  logic        c_flag;
  logic [31:0] operand;
  logic        carry_out;
  logic        ext_space;

  int checks;
  int errors;
  bit done;

  opnd_shifter u_dut (
    .instr_lo  (instr_lo),
    .imm_sel   (imm_sel),
    .rm_val    (rm_val),
    .rs_lo     (rs_lo),
    .c_flag    (c_flag),
    .operand   (operand),
    .carry_out (carry_out),
    .ext_space (ext_space)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic        isel;
    logic [11:0] ins;
    logic [31:0] rm;
    logic [7:0]  rs;
    logic        c;
    logic [31:0] exp_v;
    logic        exp_c;
    logic        exp_x;
  } vec_t;

  localparam int NV = 31;
  localparam logic [31:0] RA = 32'h9765_4321;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  1'b1, 12'h0AB, RA, 8'd0,  1'b1, 32'h0000_00AB, 1'b1, 1'b0}, // R1 R2 rot 0
    '{8'd2,  1'b1, 12'h1FF, RA, 8'd0,  1'b0, 32'hC000_003F, 1'b1, 1'b0}, // R1 R2 rot 2
    '{8'd2,  1'b1, 12'h43F, RA, 8'd0,  1'b1, 32'h3F00_0000, 1'b0, 1'b0}, // R1 R2 rot 8
    '{8'd3,  1'b0, 12'h200, RA, 8'd0,  1'b0, 32'h7654_3210, 1'b1, 1'b0}, // R3 lsl 4
    '{8'd3,  1'b0, 12'h000, RA, 8'd0,  1'b1, RA,            1'b1, 1'b0}, // R3 lsl 0
    '{8'd3,  1'b0, 12'hF80, RA, 8'd0,  1'b1, 32'h8000_0000, 1'b0, 1'b0}, // R3 lsl 31
    '{8'd4,  1'b0, 12'h420, RA, 8'd0,  1'b1, 32'h0097_6543, 1'b0, 1'b0}, // R4 lsr 8
    '{8'd4,  1'b0, 12'h020, RA, 8'd0,  1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R4 lsr 0->32
    '{8'd4,  1'b0, 12'hFA0, RA, 8'd0,  1'b1, 32'h0000_0001, 1'b0, 1'b0}, // R4 lsr 31
    '{8'd4,  1'b0, 12'h040, RA, 8'd0,  1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R4 asr 0->32
    '{8'd4,  1'b0, 12'h240, RA, 8'd0,  1'b1, 32'hF976_5432, 1'b0, 1'b0}, // R4 asr 4
    '{8'd5,  1'b0, 12'h460, RA, 8'd0,  1'b1, 32'h2197_6543, 1'b0, 1'b0}, // R5 ror 8
    '{8'd5,  1'b0, 12'h060, RA, 8'd0,  1'b0, 32'h4BB2_A190, 1'b1, 1'b0}, // R5 rrx c=0
    '{8'd5,  1'b0, 12'h060, RA, 8'd0,  1'b1, 32'hCBB2_A190, 1'b1, 1'b0}, // R5 rrx c=1
    '{8'd6,  1'b0, 12'h310, RA, 8'd0,  1'b1, RA,            1'b1, 1'b0}, // R6 lsl reg 0
    '{8'd6,  1'b0, 12'h370, RA, 8'd0,  1'b0, RA,            1'b0, 1'b0}, // R6 ror reg 0
    '{8'd6,  1'b0, 12'h350, RA, 8'd0,  1'b1, RA,            1'b1, 1'b0}, // R6 asr reg 0
    '{8'd7,  1'b0, 12'h310, RA, 8'd4,  1'b0, 32'h7654_3210, 1'b1, 1'b0}, // R7 lsl 4
    '{8'd7,  1'b0, 12'h310, RA, 8'd32, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R7 lsl 32
    '{8'd7,  1'b0, 12'h310, RA, 8'd33, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R7 lsl 33
    '{8'd7,  1'b0, 12'h310, RA, 8'd255,1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R7 lsl 255
    '{8'd8,  1'b0, 12'h330, RA, 8'd1,  1'b0, 32'h4BB2_A190, 1'b1, 1'b0}, // R8 lsr 1
    '{8'd8,  1'b0, 12'h330, RA, 8'd32, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R8 lsr 32
    '{8'd8,  1'b0, 12'h330, RA, 8'd40, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R8 lsr 40
    '{8'd9,  1'b0, 12'h350, RA, 8'd4,  1'b1, 32'hF976_5432, 1'b0, 1'b0}, // R9 asr 4
    '{8'd9,  1'b0, 12'h350, RA, 8'd200,1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R9 asr 200
    '{8'd9,  1'b0, 12'h350, 32'h1765_4321, 8'd32, 1'b1, 32'h0, 1'b0, 1'b0}, // R9 asr 32 pos
    '{8'd10, 1'b0, 12'h370, RA, 8'd8,  1'b1, 32'h2197_6543, 1'b0, 1'b0}, // R10 ror 8
    '{8'd10, 1'b0, 12'h370, RA, 8'd32, 1'b0, RA,            1'b1, 1'b0}, // R10 ror 32
    '{8'd10, 1'b0, 12'h370, RA, 8'd36, 1'b1, 32'h1976_5432, 1'b0, 1'b0}, // R10 ror 36
    '{8'd11, 1'b0, 12'h090, RA, 8'd5,  1'b1, 32'h0000_0000, 1'b1, 1'b1}  // R11 ext
  };

  task automatic check(input string tag, input logic [31:0] ev,
                       input logic ec, input logic ex);
    checks++;
    if (operand !== ev || carry_out !== ec || ext_space !== ex) begin
      errors++;
      $display("FAIL %s: got op=%h cy=%b ext=%b, expected op=%h cy=%b ext=%b",
               tag, operand, carry_out, ext_space, ev, ec, ex);
    end
  endtask

  task automatic drive(input logic is, input logic [11:0] ins, input logic [31:0] rm,
                       input logic [7:0] rs, input logic c);
    @(posedge clk);
    imm_sel  = is;
    instr_lo = ins;
    rm_val   = rm;
    rs_lo    = rs;
    c_flag   = c;
    @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    imm_sel = 1'b0; instr_lo = '0; rm_val = '0; rs_lo = '0; c_flag = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset R3", 32'h0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].isel, VECS[i].ins, VECS[i].rm, VECS[i].rs, VECS[i].c);
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            VECS[i].exp_v, VECS[i].exp_c, VECS[i].exp_x);
    end

    // R11: same bits with immediate select are a plain rotated constant
    drive(1'b1, 12'h090, RA, 8'd5, 1'b0);
    check("R11 imm not ext", 32'h0000_0090, 1'b0, 1'b0);
    // R11: bit 7 clear with bit 4 set is a register shift, not extension
    drive(1'b0, 12'h010, RA, 8'd0, 1'b1);
    check("R11 reg form", RA, 1'b1, 1'b0);

    // R7 sweep on all-ones: carry 1 up to 32, then 0
    for (int n = 1; n <= 40; n++) begin
      drive(1'b0, 12'h310, 32'hFFFF_FFFF, 8'(n), 1'b0);
      check($sformatf("R7 sweep n=%0d", n),
            (n >= 32) ? 32'h0 : (32'hFFFF_FFFF << n), (n <= 32), 1'b0);
    end
    // R8 sweep with a single top bit: carry only at exactly 32
    for (int n = 1; n <= 40; n++) begin
      drive(1'b0, 12'h330, 32'h8000_0000, 8'(n), 1'b1);
      check($sformatf("R8 sweep n=%0d", n),
            (n >= 32) ? 32'h0 : (32'h8000_0000 >> n), (n == 32), 1'b0);
    end
    // R1 sweep: single bit rotated by every even amount
    for (int r = 0; r < 16; r++) begin
      drive(1'b1, 12'((r << 8) | 1), RA, 8'd0, 1'b1);
      check($sformatf("R1 sweep r=%0d", r),
            (r == 0) ? 32'h1 : (32'h1 << (32 - 2 * r)),
            (r == 0) ? 1'b1 : (r == 16), 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule